// File: doc/BRIEF.md
# Directory-Coherent Cache Controller

This block is the coherence controller that sits beside one processor on a node of a machine where coherence is kept by a home directory and not by snooping a shared bus. It holds a small direct-mapped write-back cache. Each line is invalid, shared (read-only) or exclusive (writable and dirty). Every coherence action goes out as an explicit point-to-point message to the home directory or comes in as one. There are no broadcasts.

A processor access that hits is answered one cycle after it is presented. On a read miss, or on a write to a line that is not exclusive, the controller sends a miss message and then waits for the directory's data reply. If the indexed line holds a dirty line of another address, the controller first sends that line back. While the processor waits, the controller still services invalidate, fetch and fetch-with-invalidate messages from the directory, in arrival order, ahead of the reply.

The processor holds its request, with stable fields, until it sees the one-cycle completion pulse. It drops the request in the cycle after that pulse.

Top module: `dircc_ctrl`

## Requirements
- R1: After reset no outgoing message and no completion pulse appear, and every line is invalid, so the first access to any address misses.
- R2: A read that finds its address in a shared or exclusive line raises `cpu_done` one cycle later with the stored word on `cpu_rdata`, and sends no message.
- R3: A read that misses sends, one cycle later, a message of type 0 (read miss) with `out_src` equal to the node id and `out_addr` equal to the processor address. The line becomes shared with the reply data. `cpu_done` rises one cycle after the reply, returning that data.
- R4: A write to an invalid, foreign or shared line sends a message of type 1 (write miss) one cycle later. When the reply arrives, the line becomes exclusive and holds the written word. A write to an exclusive line with a matching tag completes in one cycle with no message. Both cases return the written word on `cpu_rdata`.
- R5: A miss whose line is exclusive for another address first sends a type 2 message (data write-back) carrying that line's address and data. The line becomes invalid, and the miss message follows in the next cycle.
- R6: An incoming type 0 message (invalidate) makes a matching shared line invalid. On an exclusive or non-matching line it has no effect and produces no message.
- R7: An incoming type 1 message (fetch) for a matching exclusive line sends a type 2 message with the line's address and data one cycle later, and the line becomes shared.
- R8: An incoming type 2 message (fetch and invalidate) for a matching exclusive line sends a type 2 message with the line's address and data one cycle later, and the line becomes invalid.
- R9: An incoming type 3 message (data reply) has an effect only while a miss is outstanding. Fetch or fetch-and-invalidate messages that do not match an exclusive line change nothing and send nothing.
- R10: When an incoming message arrives in the same cycle that an idle controller sees a processor request, the message is handled first and the access starts a cycle later. A write-back caused by a directory message takes the outgoing port ahead of a queued miss message, which then follows one cycle later.
- R11: Directory messages arriving while a miss is outstanding are applied to the cache before the reply, and the reply then installs the line in its final state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access request, held until completion |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle pulse when the access completes |
| cpu_rdata | output | DATA_W | Word returned with `cpu_done` |
| in_valid | input | 1 | Incoming directory message valid |
| in_type | input | 2 | 0 invalidate, 1 fetch, 2 fetch and invalidate, 3 data reply |
| in_addr | input | ADDR_W | Address of the incoming message |
| in_data | input | DATA_W | Data of a reply |
| out_valid | output | 1 | Outgoing message valid for one cycle |
| out_type | output | 2 | 0 read miss, 1 write miss, 2 data write-back |
| out_src | output | NODE_W | Id of this node |
| out_addr | output | ADDR_W | Address of the outgoing message |
| out_data | output | DATA_W | Data of a write-back, or the write word of a write miss |

## Verification
The assertions rely on several properties of the inputs. The processor keeps its request fields stable until `cpu_done` and drops the request in the following cycle. The directory never sends a reply unless a miss is outstanding. The network takes every outgoing message in the cycle it appears. The stimulus drives the processor and the directory from one sequential bench task, and that task issues a reply only after it has seen the miss message. Random probes are drawn from a small address set so that they often hit live lines. The directed cases place a probe exactly in the request cycle, in the cycle between a victim write-back and its miss, and while a miss is outstanding.

// File: rtl/dircc_pkg.sv
package dircc_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_SEND = 2'd1,
    FS_WAIT = 2'd2
  } miss_state_e;

  // outgoing message kinds
  localparam logic [1:0] OUT_RDMISS = 2'd0;
  localparam logic [1:0] OUT_WRMISS = 2'd1;
  localparam logic [1:0] OUT_WB     = 2'd2;

  // incoming message kinds
  localparam logic [1:0] IN_INV   = 2'd0;
  localparam logic [1:0] IN_FETCH = 2'd1;
  localparam logic [1:0] IN_FINV  = 2'd2;
  localparam logic [1:0] IN_REPLY = 2'd3;

endpackage

// File: rtl/dircc_line_store.sv
module dircc_line_store
  import dircc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_state_e       ra_state,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_state_e       rb_state,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_state_e       wr_state,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int LINES = 1 << IDX_W;

  line_state_e       st_v  [LINES];
  logic [TAG_W-1:0]  tag_v [LINES];
  logic [DATA_W-1:0] dat_v [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              sel_w;
    line_state_e       st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;

    assign sel_w = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= LS_INV;
      end else if (sel_w) begin
        st_q <= wr_state;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_w) begin
        tag_q <= wr_tag;
        dat_q <= wr_data;
      end
    end

    assign st_v[g]  = st_q;
    assign tag_v[g] = tag_q;
    assign dat_v[g] = dat_q;
  end

  assign ra_state = st_v[ra_idx];
  assign ra_tag   = tag_v[ra_idx];
  assign ra_data  = dat_v[ra_idx];
  assign rb_state = st_v[rb_idx];
  assign rb_tag   = tag_v[rb_idx];
  assign rb_data  = dat_v[rb_idx];

endmodule

// File: rtl/dircc_probe_unit.sv
module dircc_probe_unit
  import dircc_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             in_valid,
  input  logic [1:0]       in_type,
  input  logic [TAG_W-1:0] in_tag,
  input  line_state_e      line_state,
  input  logic [TAG_W-1:0] line_tag,
  output logic             wr_req,
  output line_state_e      wr_state,
  output logic             wb_req
);

  logic match_w;

  assign match_w = in_valid && (line_state != LS_INV) && (line_tag == in_tag);

  always_comb begin
    wr_req   = 1'b0;
    wr_state = line_state;
    wb_req   = 1'b0;
    if (match_w) begin
      unique case (in_type)
        IN_INV: begin
          if (line_state == LS_SHR) begin
            wr_req   = 1'b1;
            wr_state = LS_INV;
          end
        end
        IN_FETCH: begin
          if (line_state == LS_EXC) begin
            wr_req   = 1'b1;
            wr_state = LS_SHR;
            wb_req   = 1'b1;
          end
        end
        IN_FINV: begin
          if (line_state == LS_EXC) begin
            wr_req   = 1'b1;
            wr_state = LS_INV;
            wb_req   = 1'b1;
          end
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/dircc_miss_fsm.sv
module dircc_miss_fsm
  import dircc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic                    in_valid,
  input  logic [1:0]              in_type,
  input  logic [DATA_W-1:0]       in_data,
  input  logic                    port_busy,
  input  line_state_e             ra_state,
  input  logic [ADDR_W-IDX_W-1:0] ra_tag,
  input  logic [DATA_W-1:0]       ra_data,
  output miss_state_e             fsm_state,
  output logic                    msg_req,
  output logic [1:0]              msg_type,
  output logic [ADDR_W-1:0]       msg_addr,
  output logic [DATA_W-1:0]       msg_data,
  output logic                    wr_req,
  output line_state_e             wr_state,
  output logic [ADDR_W-IDX_W-1:0] wr_tag,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    done_d,
  output logic [DATA_W-1:0]       rdata_d
);

  localparam int TAG_W = ADDR_W - IDX_W;

  miss_state_e        state_q, state_d;
  logic [TAG_W-1:0]   cpu_tag;
  logic [IDX_W-1:0]   cpu_idx;
  logic               tag_hit;
  logic               idle_go;
  logic [1:0]         miss_type;
  logic [DATA_W-1:0]  miss_data;

  assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
  assign cpu_idx   = cpu_addr[IDX_W-1:0];
  assign tag_hit   = (ra_state != LS_INV) && (ra_tag == cpu_tag);
  assign idle_go   = cpu_req && !in_valid;
  assign miss_type = cpu_we ? OUT_WRMISS : OUT_RDMISS;
  assign miss_data = cpu_we ? cpu_wdata : '0;
  assign fsm_state = state_q;

  always_comb begin
    state_d  = state_q;
    msg_req  = 1'b0;
    msg_type = miss_type;
    msg_addr = cpu_addr;
    msg_data = miss_data;
    wr_req   = 1'b0;
    wr_state = ra_state;
    wr_tag   = ra_tag;
    wr_data  = ra_data;
    done_d   = 1'b0;
    rdata_d  = ra_data;
    unique case (state_q)
      FS_IDLE: begin
        if (idle_go) begin
          if (tag_hit && (!cpu_we || ra_state == LS_EXC)) begin
            done_d = 1'b1;
            if (cpu_we) begin
              wr_req   = 1'b1;
              wr_state = LS_EXC;
              wr_data  = cpu_wdata;
              rdata_d  = cpu_wdata;
            end
          end else if (!tag_hit && ra_state == LS_EXC) begin
            msg_req  = 1'b1;
            msg_type = OUT_WB;
            msg_addr = {ra_tag, cpu_idx};
            msg_data = ra_data;
            wr_req   = 1'b1;
            wr_state = LS_INV;
            state_d  = FS_SEND;
          end else begin
            msg_req = 1'b1;
            state_d = FS_WAIT;
          end
        end
      end
      FS_SEND: begin
        if (!port_busy) begin
          msg_req = 1'b1;
          state_d = FS_WAIT;
        end
      end
      FS_WAIT: begin
        if (in_valid && in_type == IN_REPLY) begin
          wr_req   = 1'b1;
          wr_state = cpu_we ? LS_EXC : LS_SHR;
          wr_tag   = cpu_tag;
          wr_data  = cpu_we ? cpu_wdata : in_data;
          done_d   = 1'b1;
          rdata_d  = cpu_we ? cpu_wdata : in_data;
          state_d  = FS_IDLE;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/dircc_ctrl.sv
module dircc_ctrl
  import dircc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 2,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              in_valid,
  input  logic [1:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [1:0]        out_type,
  output logic [NODE_W-1:0] out_src,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  localparam int TAG_W = ADDR_W - IDX_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  line_state_e       cr_state, pr_state;
  logic [TAG_W-1:0]  cr_tag, pr_tag;
  logic [DATA_W-1:0] cr_data, pr_data;

  logic              pb_wr_req, pb_wb_req;
  line_state_e       pb_wr_state;

  miss_state_e       fsm_state;
  logic              fsm_msg_req, fsm_wr_req, fsm_done_d;
  logic [1:0]        fsm_msg_type;
  logic [ADDR_W-1:0] fsm_msg_addr;
  logic [DATA_W-1:0] fsm_msg_data, fsm_wr_data, fsm_rdata_d;
  line_state_e       fsm_wr_state;
  logic [TAG_W-1:0]  fsm_wr_tag;

  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  line_state_e       st_wr_state;
  logic [TAG_W-1:0]  st_wr_tag;
  logic [DATA_W-1:0] st_wr_data;

  dircc_line_store #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ra_idx   (cpu_addr[IDX_W-1:0]),
    .ra_state (cr_state),
    .ra_tag   (cr_tag),
    .ra_data  (cr_data),
    .rb_idx   (in_addr[IDX_W-1:0]),
    .rb_state (pr_state),
    .rb_tag   (pr_tag),
    .rb_data  (pr_data),
    .wr_en    (st_wr_en),
    .wr_idx   (st_wr_idx),
    .wr_state (st_wr_state),
    .wr_tag   (st_wr_tag),
    .wr_data  (st_wr_data)
  );

  dircc_probe_unit #(
    .TAG_W (TAG_W)
  ) u_probe (
    .in_valid   (in_valid),
    .in_type    (in_type),
    .in_tag     (in_addr[ADDR_W-1:IDX_W]),
    .line_state (pr_state),
    .line_tag   (pr_tag),
    .wr_req     (pb_wr_req),
    .wr_state   (pb_wr_state),
    .wb_req     (pb_wb_req)
  );

  dircc_miss_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .in_valid  (in_valid),
    .in_type   (in_type),
    .in_data   (in_data),
    .port_busy (pb_wb_req),
    .ra_state  (cr_state),
    .ra_tag    (cr_tag),
    .ra_data   (cr_data),
    .fsm_state (fsm_state),
    .msg_req   (fsm_msg_req),
    .msg_type  (fsm_msg_type),
    .msg_addr  (fsm_msg_addr),
    .msg_data  (fsm_msg_data),
    .wr_req    (fsm_wr_req),
    .wr_state  (fsm_wr_state),
    .wr_tag    (fsm_wr_tag),
    .wr_data   (fsm_wr_data),
    .done_d    (fsm_done_d),
    .rdata_d   (fsm_rdata_d)
  );

  // directory-driven updates win the single write port
  always_comb begin
    if (pb_wr_req) begin
      st_wr_en    = 1'b1;
      st_wr_idx   = in_addr[IDX_W-1:0];
      st_wr_state = pb_wr_state;
      st_wr_tag   = pr_tag;
      st_wr_data  = pr_data;
    end else begin
      st_wr_en    = fsm_wr_req;
      st_wr_idx   = cpu_addr[IDX_W-1:0];
      st_wr_state = fsm_wr_state;
      st_wr_tag   = fsm_wr_tag;
      st_wr_data  = fsm_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      cpu_done  <= 1'b0;
    end else begin
      out_valid <= pb_wb_req || fsm_msg_req;
      cpu_done  <= fsm_done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pb_wb_req) begin
      out_type <= OUT_WB;
      out_addr <= in_addr;
      out_data <= pr_data;
    end else if (fsm_msg_req) begin
      out_type <= fsm_msg_type;
      out_addr <= fsm_msg_addr;
      out_data <= fsm_msg_data;
    end
    if (fsm_done_d) begin
      cpu_rdata <= fsm_rdata_d;
    end
  end

  assign out_src = NODE_W'(NODE_ID);

endmodule

// File: rtl/dircc_ctrl_checker.sv
module dircc_ctrl_checker
  import dircc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    cpu_req,
  input logic                    cpu_done,
  input logic                    in_valid,
  input logic [1:0]              in_type,
  input logic [ADDR_W-1:0]       in_addr,
  input logic                    out_valid,
  input logic [1:0]              out_type,
  input logic [ADDR_W-1:0]       out_addr,
  input miss_state_e             fsm_state,
  input line_state_e             pr_state,
  input logic [ADDR_W-IDX_W-1:0] pr_tag
);

  // a completed access never shares its cycle with a message
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_done |-> !out_valid);

  // after a victim write-back, the miss message follows if the port is free
  p_victim_then_miss_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fsm_state == FS_SEND) && !in_valid |=> out_valid && (out_type != OUT_WB));

  // a fetch that matches an exclusive line is answered with its write-back
  p_fetch_answer_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid && (in_type == IN_FETCH) && (pr_state == LS_EXC) &&
    (pr_tag == in_addr[ADDR_W-1:IDX_W])
    |=> out_valid && (out_type == OUT_WB) && (out_addr == $past(in_addr)));

  // completion comes only from an idle lookup or a reply while waiting
  p_done_origin_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_done |-> ($past(fsm_state) == FS_IDLE) ||
                 (($past(fsm_state) == FS_WAIT) && $past(in_valid) &&
                  ($past(in_type) == IN_REPLY)));

  // a directory message in the request cycle defers the access
  p_defer_access_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fsm_state == FS_IDLE) && cpu_req && in_valid
    |=> !cpu_done && !(out_valid && (out_type != OUT_WB)));

endmodule

bind dircc_ctrl dircc_ctrl_checker #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cpu_req    (cpu_req),
  .cpu_done   (cpu_done),
  .in_valid   (in_valid),
  .in_type    (in_type),
  .in_addr    (in_addr),
  .out_valid  (out_valid),
  .out_type   (out_type),
  .out_addr   (out_addr),
  .fsm_state  (fsm_state),
  .pr_state   (pr_state),
  .pr_tag     (pr_tag)
);

// File: tb/dircc_ctrl_bench.sv
`timescale 1ns/1ps
module dircc_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [7:0]  cpu_addr;
  logic [15:0] cpu_wdata;
  logic        cpu_done;
  logic [15:0] cpu_rdata;
  logic        in_valid;
  logic [1:0]  in_type;
  logic [7:0]  in_addr;
  logic [15:0] in_data;
  logic        out_valid;
  logic [1:0]  out_type;
  logic [1:0]  out_src;
  logic [7:0]  out_addr;
  logic [15:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model of the cache: 0 invalid, 1 shared, 2 exclusive
  int         m_st  [4];
  logic [5:0] m_tag [4];
  logic [15:0] m_dat [4];

  dircc_ctrl u_dircc_ctrl (
    .clk (clk), .rst_n (rst_n),
    .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
    .cpu_wdata (cpu_wdata), .cpu_done (cpu_done), .cpu_rdata (cpu_rdata),
    .in_valid (in_valid), .in_type (in_type), .in_addr (in_addr),
    .in_data (in_data), .out_valid (out_valid), .out_type (out_type),
    .out_src (out_src), .out_addr (out_addr), .out_data (out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit line_match(input logic [7:0] a);
    return (m_st[a[1:0]] != 0) && (m_tag[a[1:0]] == a[7:2]);
  endfunction

  // one directory message at a negedge; checked one edge later
  task automatic probe_step(input logic [1:0] t, input logic [7:0] a);
    int    i;
    bit    m, wb;
    string rq;
    i  = int'(a[1:0]);
    m  = line_match(a);
    wb = m && (m_st[i] == 2) && (t == 2'd1 || t == 2'd2);
    rq = (t == 2'd0) ? "R6" : (!m || m_st[i] != 2) ? "R9" : (t == 2'd1) ? "R7" : "R8";
    in_valid = 1'b1; in_type = t; in_addr = a; in_data = 16'($urandom);
    @(negedge clk);
    in_valid = 1'b0;
    chk(rq, "out_valid after probe", out_valid, wb);
    if (wb) begin
      chk(rq, "wb type", out_type, 2);
      chk(rq, "wb addr", out_addr, a);
      chk(rq, "wb data", out_data, m_dat[i]);
    end
    chk("R10", "no completion during probe", cpu_done, 0);
    if (m) begin
      if (t == 2'd0 && m_st[i] == 1) m_st[i] = 0;
      if (t == 2'd1 && m_st[i] == 2) m_st[i] = 1;
      if (t == 2'd2 && m_st[i] == 2) m_st[i] = 0;
    end
  endtask

  // mode 0 plain, 1 probe while waiting, 2 probe in the victim-to-miss gap,
  // 3 probe in the request cycle
  task automatic access(input bit we, input logic [7:0] a, input logic [15:0] wd,
                        input int mode, input logic [1:0] pt, input logic [7:0] pa);
    int          i;
    bit          hit, victim;
    logic [15:0] rd;
    string       rq;
    i  = int'(a[1:0]);
    rq = we ? "R4" : "R3";
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (mode == 3) probe_step(pt, pa);
    hit = line_match(a);
    if (hit && (!we || m_st[i] == 2)) begin
      @(negedge clk);
      chk(we ? "R4" : "R2", "hit done", cpu_done, 1);
      chk(we ? "R4" : "R2", "hit rdata", cpu_rdata, we ? wd : m_dat[i]);
      chk("R2", "hit sends nothing", out_valid, 0);
      if (we) m_dat[i] = wd;
      cpu_req = 1'b0;
      return;
    end
    victim = (m_st[i] == 2);
    if (victim) begin
      @(negedge clk);
      chk("R5", "victim valid", out_valid, 1);
      chk("R5", "victim type", out_type, 2);
      chk("R5", "victim addr", out_addr, {m_tag[i], a[1:0]});
      chk("R5", "victim data", out_data, m_dat[i]);
      m_st[i] = 0;
      if (mode == 2) begin
        for (int k = 0; k < 4; k++) begin
          if (m_st[k] == 2) begin
            probe_step(2'd2, {m_tag[k], 2'(k)});
            break;
          end
        end
      end
    end
    @(negedge clk);
    chk(rq, "miss valid", out_valid, 1);
    chk(rq, "miss type", out_type, we ? 1 : 0);
    chk(rq, "miss addr", out_addr, a);
    chk(rq, "miss src", out_src, 1);
    chk(rq, "no early done", cpu_done, 0);
    if (mode == 1) probe_step(pt, pa);
    for (int w = 0; w < int'($urandom % 3); w++) begin
      @(negedge clk);
      chk("R11", "quiet while waiting", {out_valid, cpu_done}, 0);
    end
    rd = 16'($urandom);
    in_valid = 1'b1; in_type = 2'd3; in_addr = a; in_data = rd;
    @(negedge clk);
    in_valid = 1'b0;
    chk(rq, "reply done", cpu_done, 1);
    chk(rq, "reply rdata", cpu_rdata, we ? wd : rd);
    chk(rq, "reply sends nothing", out_valid, 0);
    m_st[i] = we ? 2 : 1; m_tag[i] = a[7:2]; m_dat[i] = we ? wd : rd;
    cpu_req = 1'b0;
  endtask

  task automatic stray_reply(input logic [7:0] a);
    in_valid = 1'b1; in_type = 2'd3; in_addr = a; in_data = 16'($urandom);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "stray reply no done", cpu_done, 0);
    chk("R9", "stray reply no message", out_valid, 0);
  endtask

  function automatic logic [7:0] pick_addr();
    return {4'd0, 2'($urandom % 4), 2'($urandom % 4)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7153));
    for (int k = 0; k < 4; k++) m_st[k] = 0;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    in_valid = 1'b0; in_type = '0; in_addr = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset out_valid", out_valid, 0);
    chk("R1", "reset done", cpu_done, 0);

    // directed cases
    access(0, 8'h05, 16'h0, 0, 0, 0);          // R1 first access misses
    access(0, 8'h05, 16'h0, 0, 0, 0);          // R2 read hit
    access(1, 8'h05, 16'hA1A1, 0, 0, 0);       // R4 upgrade of shared
    access(1, 8'h05, 16'hB2B2, 0, 0, 0);       // R4 exclusive hit
    access(0, 8'h09, 16'h0, 0, 0, 0);          // R5 dirty victim
    probe_step(2'd1, 8'h09);                   // R9 fetch on shared
    access(1, 8'h0E, 16'hC3C3, 0, 0, 0);
    probe_step(2'd1, 8'h0E);                   // R7 fetch
    access(0, 8'h0E, 16'h0, 0, 0, 0);          // R7 line now shared
    access(1, 8'h0E, 16'hD4D4, 0, 0, 0);
    probe_step(2'd2, 8'h0E);                   // R8 fetch and invalidate
    access(0, 8'h0E, 16'h0, 0, 0, 0);          // R8 line gone
    access(0, 8'h03, 16'h0, 0, 0, 0);
    probe_step(2'd0, 8'h03);                   // R6 invalidate shared
    probe_step(2'd0, 8'h03);                   // R6 no effect on invalid
    access(0, 8'h03, 16'h0, 0, 0, 0);
    stray_reply(8'h03);                        // R9 ignored reply
    access(0, 8'h03, 16'h0, 0, 0, 0);          // R9 old data still there
    access(1, 8'h03, 16'hE5E5, 3, 2'd0, 8'h03);// R10 probe in request cycle
    probe_step(2'd0, 8'h03);                   // R6 invalidate on exclusive
    probe_step(2'd1, 8'h03);                   // R7 downgrade
    access(1, 8'h03, 16'hF6F6, 1, 2'd0, 8'h03);// R11 invalidate while waiting
    access(0, 8'h03, 16'h0, 0, 0, 0);          // R11 hit holds written word
    access(1, 8'h05, 16'h1111, 0, 0, 0);
    access(1, 8'h0E, 16'h2222, 0, 0, 0);
    access(0, 8'h09, 16'h0, 2, 0, 0);          // R10 probe takes port in gap

    // random traffic
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 10 < 7) begin
        access(bit'($urandom % 2), pick_addr(), 16'($urandom), int'($urandom % 4),
               2'($urandom % 3), pick_addr());
      end else if ($urandom % 8 == 0) begin
        stray_reply(pick_addr());
      end else begin
        probe_step(2'($urandom % 3), pick_addr());
      end
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        chk("R9", "idle quiet", {out_valid, cpu_done}, 0);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule